// File: doc/BRIEF.md
# Time-Triggered Reordering Admission Stage

This block sits in front of a single shared transmit FIFO and decides, one packet descriptor at a time, whether that descriptor may enter the queue. Descriptors are either time-sensitive (TS) or best-effort (BE).

TS descriptors follow a pre-planned schedule. A mapping table turns the descriptor's flow and period number into a position in a sequence table. The sequence table holds the planned transmission time for every position in one hyper period. TS descriptors must reach the FIFO in sequence order. One that arrives ahead of its turn is parked in a small bank of holding registers. It is released automatically once every earlier position has been admitted.

A BE descriptor gets an eligible time derived from the moment the link is expected to fall idle. It is admitted only if it finishes before the next planned TS slot and no TS descriptor is waiting in the bank. The schedule repeats: after the last configured position the sequence restarts at position 0, and every planned time is shifted by one hyper-period length. Software loads the mapping and sequence tables through simple write ports. The enqueue side carries the eligible time and a rank for the downstream egress gate.

Top module: `tt_reorder_admit`

## Requirements
- R1: After reset, in_ready is 1, enq_valid, dec_valid and ovf are 0, the expected sequence position is 0, the hyper-period offset is 0 and the link-idle time is 0.
- R2: A TS descriptor's sequence position is the mapping-table entry at key {in_flow, in_period}. Its planned time is the sequence-table time at that position plus the current hyper-period offset. The enqueue fields flow, period and length repeat the descriptor's own.
- R3: A TS descriptor whose position equals the expected position is admitted. enq_valid pulses in the cycle after acceptance with enq_ts=1 and enq_elig equal to its planned time. dec_code reports ADMIT. Decision codes: 0 ADMIT, 1 STORE, 2 DROP.
- R4: A TS descriptor ahead of its turn is parked in a free holding register and reported as STORE, with no enqueue.
- R5: When the expected position advances onto a parked entry, that entry is enqueued in the following cycle. Chains continue one per cycle in position order. in_ready is 0 while a release is pending.
- R6: A BE descriptor's eligible time is the larger of the link-idle time and the `now` input at acceptance.
- R7: A BE descriptor is admitted only if its eligible time plus in_len*cfg_byte_ns is not later than the planned time of the expected position and the bank is empty. Otherwise it is reported as DROP with no enqueue.
- R8: Each enqueue sets the link-idle time to the enqueued eligible time plus len*cfg_byte_ns.
- R9: Advancing from position cfg_last_idx returns to position 0 and adds cfg_hyper_ns to the hyper-period offset.
- R10: An out-of-turn TS descriptor that finds all holding registers occupied is reported as DROP. It raises ovf, which stays 1 until reset.
- R11: An out-of-turn TS descriptor whose position is already parked is reported as DROP. The parked copy is kept.
- R12: enq_rank is always 0.
- R13: At most one descriptor is accepted per cycle. dec_valid pulses exactly in the cycle after each accepted descriptor, and release enqueues carry no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_ns | input | BYTE_W | Link time per byte in ns |
| cfg_last_idx | input | IDX_W | Last used sequence position of the hyper period |
| cfg_hyper_ns | input | TIME_W | Hyper-period length in ns |
| map_we | input | 1 | Mapping-table write enable |
| map_key | input | FLOW_W+PERIOD_W | Mapping-table write key {flow, period} |
| map_idx | input | IDX_W | Sequence position written |
| plan_we | input | 1 | Sequence-table write enable |
| plan_idx | input | IDX_W | Sequence position to write |
| plan_time | input | TIME_W | Planned time within the hyper period |
| now | input | TIME_W | Synchronized network time |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor may be accepted |
| in_ts | input | 1 | 1 = time-sensitive, 0 = best-effort |
| in_flow | input | FLOW_W | Flow number |
| in_period | input | PERIOD_W | Period number within the hyper period |
| in_len | input | LEN_W | Wire length in bytes including preamble and gap |
| enq_valid | output | 1 | FIFO write strobe |
| enq_ts | output | 1 | Type of enqueued descriptor |
| enq_flow | output | FLOW_W | Flow of enqueued descriptor |
| enq_period | output | PERIOD_W | Period of enqueued descriptor |
| enq_len | output | LEN_W | Length of enqueued descriptor |
| enq_elig | output | TIME_W | Eligible transmission time |
| enq_rank | output | RANK_W | Rank, always 0 |
| dec_valid | output | 1 | Decision strobe for an accepted descriptor |
| dec_code | output | 2 | 0 ADMIT, 1 STORE, 2 DROP |
| ovf | output | 1 | Sticky holding-bank overflow |

## Verification
The checker enforces, on every cycle, the pairing between handshake, decision strobe and enqueue strobe. It checks that STORE and DROP never enqueue, that a pending release always enqueues a TS descriptor next cycle, and that overflow is sticky and caused by a DROP. It also checks that a BE enqueue is never earlier than the time it was accepted at and never happens with a descriptor parked. The actual eligible times, the fit boundary of BE packets, the release order across chains, wrapping with the hyper-period offset and duplicate handling depend on table contents and history. Only the bench's scenarios, run against an arithmetic model, show those.

// File: rtl/tra_pkg.sv
package tra_pkg;
   typedef enum logic [1:0] {
      DEC_ADMIT = 2'd0,
      DEC_STORE = 2'd1,
      DEC_DROP  = 2'd2
   } dec_e;
endpackage

// File: rtl/tra_idx_table.sv
// Flow/period key to sequence-position map, written by configuration.
module tra_idx_table #(
   parameter int KEY_W = 8,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             we,
   input  logic [KEY_W-1:0] waddr,
   input  logic [IDX_W-1:0] wdata,
   input  logic [KEY_W-1:0] raddr,
   output logic [IDX_W-1:0] rdata
);
   localparam int DEPTH = 1 << KEY_W;

   logic [IDX_W-1:0] map_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) map_q[waddr] <= wdata;
   end

   assign rdata = map_q[raddr];
endmodule

// File: rtl/tra_seq_table.sv
// Planned times per sequence position plus the park-valid and slot fields.
module tra_seq_table #(
   parameter int IDX_W  = 6,
   parameter int TIME_W = 48,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [TIME_W-1:0] cfg_time,
   input  logic              set_en,
   input  logic [IDX_W-1:0]  set_idx,
   input  logic [SLOT_W-1:0] set_slot,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   input  logic [IDX_W-1:0]  a_idx,
   output logic [TIME_W-1:0] a_time,
   output logic              a_pv,
   output logic [SLOT_W-1:0] a_slot,
   input  logic [IDX_W-1:0]  b_idx,
   output logic              b_pv
);
   localparam int DEPTH = 1 << IDX_W;

   logic [TIME_W-1:0] plan_q [DEPTH];
   logic [SLOT_W-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0]  pv_q;

   always_ff @(posedge clk) begin
      if (cfg_we) plan_q[cfg_idx] <= cfg_time;
   end

   always_ff @(posedge clk) begin
      if (set_en) slot_q[set_idx] <= set_slot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q <= '0;
      end else begin
         if (clr_en) pv_q[clr_idx] <= 1'b0;
         if (set_en) pv_q[set_idx] <= 1'b1;
      end
   end

   assign a_time = plan_q[a_idx];
   assign a_pv   = pv_q[a_idx];
   assign a_slot = slot_q[a_idx];
   assign b_pv   = pv_q[b_idx];
endmodule

// File: rtl/tra_hold_bank.sv
// Holding registers for TS descriptors that arrived ahead of their turn.
module tra_hold_bank #(
   parameter int HOLD_N = 4,
   parameter int DESC_W = 20,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic [DESC_W-1:0] ins_data,
   input  logic              rel_en,
   input  logic [SLOT_W-1:0] rel_slot,
   output logic [DESC_W-1:0] rel_data,
   output logic [SLOT_W-1:0] free_slot,
   output logic              full,
   output logic              any
);
   logic [HOLD_N-1:0] occ_v;
   logic [DESC_W-1:0] dat_a [HOLD_N];

   for (genvar s = 0; s < HOLD_N; s++) begin : g_slot
      logic              occ_r;
      logic [DESC_W-1:0] dat_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_r <= 1'b0;
         end else if (ins_en && free_slot == SLOT_W'(s)) begin
            occ_r <= 1'b1;
         end else if (rel_en && rel_slot == SLOT_W'(s)) begin
            occ_r <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (ins_en && free_slot == SLOT_W'(s)) dat_r <= ins_data;
      end

      assign occ_v[s] = occ_r;
      assign dat_a[s] = dat_r;
   end

   always_comb begin
      free_slot = '0;
      for (int s = HOLD_N - 1; s >= 0; s--) begin
         if (!occ_v[s]) free_slot = SLOT_W'(s);
      end
   end

   assign full     = &occ_v;
   assign any      = |occ_v;
   assign rel_data = dat_a[rel_slot];
endmodule

// File: rtl/tt_reorder_admit.sv
module tt_reorder_admit
   import tra_pkg::*;
#(
   parameter int FLOW_W   = 4,
   parameter int PERIOD_W = 4,
   parameter int IDX_W    = 6,
   parameter int TIME_W   = 48,
   parameter int LEN_W    = 12,
   parameter int BYTE_W   = 8,
   parameter int HOLD_N   = 4,
   parameter int RANK_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [BYTE_W-1:0]            cfg_byte_ns,
   input  logic [IDX_W-1:0]             cfg_last_idx,
   input  logic [TIME_W-1:0]            cfg_hyper_ns,
   input  logic                         map_we,
   input  logic [FLOW_W+PERIOD_W-1:0]   map_key,
   input  logic [IDX_W-1:0]             map_idx,
   input  logic                         plan_we,
   input  logic [IDX_W-1:0]             plan_idx,
   input  logic [TIME_W-1:0]            plan_time,
   input  logic [TIME_W-1:0]            now,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic                         in_ts,
   input  logic [FLOW_W-1:0]            in_flow,
   input  logic [PERIOD_W-1:0]          in_period,
   input  logic [LEN_W-1:0]             in_len,
   output logic                         enq_valid,
   output logic                         enq_ts,
   output logic [FLOW_W-1:0]            enq_flow,
   output logic [PERIOD_W-1:0]          enq_period,
   output logic [LEN_W-1:0]             enq_len,
   output logic [TIME_W-1:0]            enq_elig,
   output logic [RANK_W-1:0]            enq_rank,
   output logic                         dec_valid,
   output logic [1:0]                   dec_code,
   output logic                         ovf
);
   localparam int KEY_W  = FLOW_W + PERIOD_W;
   localparam int SLOT_W = (HOLD_N > 1) ? $clog2(HOLD_N) : 1;
   localparam int DESC_W = FLOW_W + PERIOD_W + LEN_W;

   if (HOLD_N < 2 || HOLD_N > 16) begin : g_bad_hold
      $error("HOLD_N must lie in 2..16");
   end
   if (KEY_W > 12 || IDX_W > 10) begin : g_bad_tables
      $error("table address widths too large");
   end
   if (TIME_W < LEN_W + BYTE_W + 1) begin : g_bad_time
      $error("TIME_W too narrow for one transmission delay");
   end

   // table and bank wiring
   logic [IDX_W-1:0]  nxt_q, arr_idx;
   logic [TIME_W-1:0] epoch_q, lst_q, nxt_time;
   logic              nxt_pv, arr_pv;
   logic [SLOT_W-1:0] nxt_slot, free_slot;
   logic              hold_full, hold_any;
   logic [DESC_W-1:0] rel_desc;

   // decision terms
   logic              rel_pend, acc, ts_hit;
   logic              take_rel, adm_ts, adm_be, park, dup, ovfl, advance;
   logic [TIME_W-1:0] nxt_plan, in_delay, rel_delay, be_base;
   logic              be_fit;
   logic [FLOW_W-1:0]   rel_flow;
   logic [PERIOD_W-1:0] rel_period;
   logic [LEN_W-1:0]    rel_len;
   dec_e              dec_n;

   tra_idx_table #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_map (
      .clk   (clk),
      .we    (map_we),
      .waddr (map_key),
      .wdata (map_idx),
      .raddr ({in_flow, in_period}),
      .rdata (arr_idx)
   );

   tra_seq_table #(.IDX_W(IDX_W), .TIME_W(TIME_W), .SLOT_W(SLOT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (plan_we),
      .cfg_idx  (plan_idx),
      .cfg_time (plan_time),
      .set_en   (park),
      .set_idx  (arr_idx),
      .set_slot (free_slot),
      .clr_en   (advance),
      .clr_idx  (nxt_q),
      .a_idx    (nxt_q),
      .a_time   (nxt_time),
      .a_pv     (nxt_pv),
      .a_slot   (nxt_slot),
      .b_idx    (arr_idx),
      .b_pv     (arr_pv)
   );

   tra_hold_bank #(.HOLD_N(HOLD_N), .DESC_W(DESC_W), .SLOT_W(SLOT_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_en    (park),
      .ins_data  ({in_flow, in_period, in_len}),
      .rel_en    (take_rel),
      .rel_slot  (nxt_slot),
      .rel_data  (rel_desc),
      .free_slot (free_slot),
      .full      (hold_full),
      .any       (hold_any)
   );

   assign {rel_flow, rel_period, rel_len} = rel_desc;

   always_comb begin
      rel_pend  = nxt_pv;
      in_ready  = !rel_pend;
      acc       = in_valid && in_ready;
      nxt_plan  = nxt_time + epoch_q;
      in_delay  = TIME_W'(in_len) * TIME_W'(cfg_byte_ns);
      rel_delay = TIME_W'(rel_len) * TIME_W'(cfg_byte_ns);
      be_base   = (now > lst_q) ? now : lst_q;
      be_fit    = (be_base + in_delay <= nxt_plan) && !hold_any;
      ts_hit    = (arr_idx == nxt_q);

      take_rel  = rel_pend;
      adm_ts    = acc && in_ts && ts_hit;
      dup       = acc && in_ts && !ts_hit && arr_pv;
      ovfl      = acc && in_ts && !ts_hit && !arr_pv && hold_full;
      park      = acc && in_ts && !ts_hit && !arr_pv && !hold_full;
      adm_be    = acc && !in_ts && be_fit;
      advance   = take_rel || adm_ts;

      if (adm_ts || adm_be) dec_n = DEC_ADMIT;
      else if (park)        dec_n = DEC_STORE;
      else                  dec_n = DEC_DROP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_q      <= '0;
         epoch_q    <= '0;
         lst_q      <= '0;
         ovf        <= 1'b0;
         enq_valid  <= 1'b0;
         enq_ts     <= 1'b0;
         enq_flow   <= '0;
         enq_period <= '0;
         enq_len    <= '0;
         enq_elig   <= '0;
         enq_rank   <= '0;
         dec_valid  <= 1'b0;
         dec_code   <= DEC_ADMIT;
      end else begin
         enq_valid <= take_rel || adm_ts || adm_be;
         dec_valid <= acc;
         dec_code  <= dec_n;
         enq_rank  <= '0;
         if (take_rel) begin
            enq_ts     <= 1'b1;
            enq_flow   <= rel_flow;
            enq_period <= rel_period;
            enq_len    <= rel_len;
            enq_elig   <= nxt_plan;
            lst_q      <= nxt_plan + rel_delay;
         end else if (adm_ts || adm_be) begin
            enq_ts     <= in_ts;
            enq_flow   <= in_flow;
            enq_period <= in_period;
            enq_len    <= in_len;
            enq_elig   <= adm_ts ? nxt_plan : be_base;
            lst_q      <= (adm_ts ? nxt_plan : be_base) + in_delay;
         end
         if (ovfl) ovf <= 1'b1;
         if (advance) begin
            if (nxt_q == cfg_last_idx) begin
               nxt_q   <= '0;
               epoch_q <= epoch_q + cfg_hyper_ns;
            end else begin
               nxt_q <= nxt_q + IDX_W'(1);
            end
         end
      end
   end

   // dup only selects DROP through dec_n; kept named for readability
   logic unused_dup;
   assign unused_dup = dup;
endmodule

// File: rtl/tra_admit_chk.sv
module tra_admit_chk #(
   parameter int TIME_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [TIME_W-1:0] now,
   input logic              enq_valid,
   input logic              enq_ts,
   input logic [TIME_W-1:0] enq_elig,
   input logic              dec_valid,
   input logic [1:0]        dec_code,
   input logic              ovf,
   input logic              rel_pend,
   input logic              hold_any
);
   p_dec_after_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(in_valid && in_ready));

   p_accept_gives_dec_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> dec_valid);

   p_admit_enqueues_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_code == 2'd0) |-> enq_valid);

   p_store_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_code == 2'd1) |-> !enq_valid);

   p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_code == 2'd2) |-> !enq_valid);

   p_release_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rel_pend |=> (enq_valid && enq_ts && !dec_valid));

   p_be_not_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !enq_ts) |-> (enq_elig >= $past(now)));

   p_be_bank_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !enq_ts) |-> $past(!hold_any));

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf) |-> ovf);

   p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> (dec_valid && dec_code == 2'd2));
endmodule

bind tt_reorder_admit tra_admit_chk #(.TIME_W(TIME_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .now       (now),
   .enq_valid (enq_valid),
   .enq_ts    (enq_ts),
   .enq_elig  (enq_elig),
   .dec_valid (dec_valid),
   .dec_code  (dec_code),
   .ovf       (ovf),
   .rel_pend  (rel_pend),
   .hold_any  (hold_any)
);

// File: tb/tt_reorder_admit_tb.sv
module tt_reorder_admit_tb;
   localparam int FW = 2, PW = 1, IW = 3, TW = 32, LW = 8, BW = 8, HN = 4, RW = 4;
   localparam int HYPER = 5000, BNS = 8, LAST = 7;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic [BW-1:0] cfg_byte_ns;
   logic [IW-1:0] cfg_last_idx;
   logic [TW-1:0] cfg_hyper_ns;
   logic          map_we;
   logic [FW+PW-1:0] map_key;
   logic [IW-1:0] map_idx;
   logic          plan_we;
   logic [IW-1:0] plan_idx;
   logic [TW-1:0] plan_time;
   logic [TW-1:0] now;
   logic          in_valid, in_ready, in_ts;
   logic [FW-1:0] in_flow;
   logic [PW-1:0] in_period;
   logic [LW-1:0] in_len;
   logic          enq_valid, enq_ts;
   logic [FW-1:0] enq_flow;
   logic [PW-1:0] enq_period;
   logic [LW-1:0] enq_len;
   logic [TW-1:0] enq_elig;
   logic [RW-1:0] enq_rank;
   logic          dec_valid;
   logic [1:0]    dec_code;
   logic          ovf;

   tt_reorder_admit #(.FLOW_W(FW), .PERIOD_W(PW), .IDX_W(IW), .TIME_W(TW),
      .LEN_W(LW), .BYTE_W(BW), .HOLD_N(HN), .RANK_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_byte_ns(cfg_byte_ns), .cfg_last_idx(cfg_last_idx),
      .cfg_hyper_ns(cfg_hyper_ns), .map_we(map_we), .map_key(map_key), .map_idx(map_idx),
      .plan_we(plan_we), .plan_idx(plan_idx), .plan_time(plan_time), .now(now),
      .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts), .in_flow(in_flow),
      .in_period(in_period), .in_len(in_len), .enq_valid(enq_valid), .enq_ts(enq_ts),
      .enq_flow(enq_flow), .enq_period(enq_period), .enq_len(enq_len),
      .enq_elig(enq_elig), .enq_rank(enq_rank), .dec_valid(dec_valid),
      .dec_code(dec_code), .ovf(ovf));

   int n_vec = 0, n_bad = 0;

   typedef struct {
      bit          ts;
      int          key;
      int          len;
      int unsigned elig;
      string       req;
   } enq_t;
   typedef struct {
      int    code;
      string req;
   } dec_t;

   enq_t exp_enq[$];
   dec_t exp_dec[$];

   // arithmetic model state
   int unsigned m_nxt = 0, m_epoch = 0, m_lst = 0, t_now = 0;
   bit          m_pv[8];
   int          m_plen[8];
   int          m_parked = 0;

   function automatic int unsigned plan_of(int i);
      return 400 + 600 * i;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (enq_valid) begin
            if (exp_enq.size() == 0) begin
               chk(0, "R13", "unexpected enqueue", 1, 0);
            end else begin
               enq_t e;
               e = exp_enq.pop_front();
               chk(enq_elig == e.elig, e.req, "eligible time", enq_elig, e.elig);
               chk(enq_ts == e.ts, e.req, "type", enq_ts, e.ts);
               chk({enq_flow, enq_period} == 3'(e.key), "R2", "key", {enq_flow, enq_period}, e.key);
               chk(enq_len == 8'(e.len), "R2", "length", enq_len, e.len);
               chk(enq_rank == 0, "R12", "rank", enq_rank, 0);
            end
         end
         if (dec_valid) begin
            if (exp_dec.size() == 0) begin
               chk(0, "R13", "unexpected decision", 1, 0);
            end else begin
               dec_t d;
               d = exp_dec.pop_front();
               chk(dec_code == 2'(d.code), d.req, "decision", dec_code, d.code);
            end
         end
      end
   end

   task automatic m_advance();
      if (m_nxt == LAST) begin
         m_nxt = 0;
         m_epoch += HYPER;
      end else begin
         m_nxt++;
      end
   endtask

   task automatic drive(bit ts, int key, int len);
      bit rdy;
      @(negedge clk);
      in_valid  = 1'b1;
      in_ts     = ts;
      {in_flow, in_period} = 3'(key);
      in_len    = 8'(len);
      do begin
         rdy = in_ready;
         @(posedge clk);
         if (!rdy) @(negedge clk);
      end while (!rdy);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (7) @(negedge clk);
   endtask

   // TS descriptor for sequence position idx; the map is key = idx ^ 5
   task automatic send_ts(int idx, int len, bit keep_open = 0);
      int          key;
      int unsigned pl;
      key = idx ^ 5;
      if (idx == int'(m_nxt)) begin
         pl = plan_of(idx) + m_epoch;
         exp_enq.push_back('{1'b1, key, len, pl, (m_epoch != 0) ? "R9" : "R3"});
         exp_dec.push_back('{0, "R3"});
         m_lst = pl + len * BNS;
         m_advance();
         while (m_pv[m_nxt]) begin
            int i;
            i = int'(m_nxt);
            pl = plan_of(i) + m_epoch;
            exp_enq.push_back('{1'b1, i ^ 5, m_plen[i], pl, "R5"});
            m_lst = pl + m_plen[i] * BNS;
            m_pv[i] = 1'b0;
            m_parked--;
            m_advance();
         end
      end else if (m_pv[idx]) begin
         exp_dec.push_back('{2, "R11"});
      end else if (m_parked == HN) begin
         exp_dec.push_back('{2, "R10"});
      end else begin
         m_pv[idx]   = 1'b1;
         m_plen[idx] = len;
         m_parked++;
         exp_dec.push_back('{1, "R4"});
      end
      drive(1'b1, key, len);
      if (!keep_open) drain();
   endtask

   task automatic send_be(int key, int len);
      int unsigned base;
      bit          from_now;
      from_now = (t_now > m_lst);
      base = from_now ? t_now : m_lst;
      if (m_parked == 0 && base + len * BNS <= plan_of(int'(m_nxt)) + m_epoch) begin
         exp_enq.push_back('{1'b0, key, len, base, from_now ? "R6" : "R8"});
         exp_dec.push_back('{0, "R7"});
         m_lst = base + len * BNS;
      end else begin
         exp_dec.push_back('{2, "R7"});
      end
      drive(1'b0, key, len);
      drain();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      rst_n = 1'b0;
      cfg_byte_ns = 8'(BNS); cfg_last_idx = 3'(LAST); cfg_hyper_ns = HYPER;
      map_we = 0; map_key = 0; map_idx = 0; plan_we = 0; plan_idx = 0; plan_time = 0;
      now = 0; in_valid = 0; in_ts = 0; in_flow = 0; in_period = 0; in_len = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
      chk(enq_valid == 0, "R1", "enq_valid", enq_valid, 0);
      chk(dec_valid == 0, "R1", "dec_valid", dec_valid, 0);
      chk(ovf == 0, "R1", "ovf", ovf, 0);

      for (int k = 0; k < 8; k++) begin
         map_we = 1; map_key = 3'(k); map_idx = 3'(k ^ 5);
         plan_we = 1; plan_idx = 3'(k); plan_time = plan_of(k);
         @(negedge clk);
      end
      map_we = 0; plan_we = 0;

      // R1/R7: link-idle time starts at 0, fit boundary exactly at 400
      send_be(2, 50);
      send_be(3, 1);

      // hyper period 0: in order, BE fills the gaps up to the boundary
      for (int i = 0; i < 8; i++) begin
         send_ts(i, 20);
         send_be(i, 55);
         send_be(i, 1);
      end

      // hyper period 1: early arrivals, release chain, time-driven BE
      send_ts(2, 30);
      send_ts(3, 40);
      send_be(1, 1);
      send_ts(0, 20);
      send_ts(1, 20, 1);
      chk(in_ready == 0, "R5", "in_ready during release", in_ready, 0);
      drain();
      chk(in_ready == 1, "R5", "in_ready after release", in_ready, 1);
      for (int i = 4; i < 8; i++) begin
         send_ts(i, 20);
         t_now = m_epoch + plan_of(i) + 300;
         now   = t_now;
         send_be(i, 37);
         send_be(i, 1);
         t_now = m_epoch + plan_of(i) + 300;
         now   = t_now;
         send_be(i, 38);
      end
      t_now = 0; now = 0;

      // hyper period 2: duplicate, overflow, recovery
      send_ts(5, 25);
      send_ts(5, 99);
      send_ts(4, 21);
      send_ts(6, 22);
      send_ts(7, 23);
      chk(ovf == 0, "R10", "ovf before bank full", ovf, 0);
      send_ts(3, 24);
      chk(ovf == 1, "R10", "ovf after overflow", ovf, 1);
      send_ts(0, 20);
      send_ts(1, 20);
      send_ts(2, 20);
      send_ts(3, 24);

      // hyper period 3: swapped pairs
      for (int p = 0; p < 4; p++) begin
         send_ts(2 * p + 1, 10 + p);
         send_be(p, 2);
         send_ts(2 * p, 20);
         send_be(p, 2);
      end
      chk(ovf == 1, "R10", "ovf stays set", ovf, 1);

      drain();
      chk(exp_enq.size() == 0, "R5", "missing enqueues", exp_enq.size(), 0);
      chk(exp_dec.size() == 0, "R13", "missing decisions", exp_dec.size(), 0);
      summary();
   end
endmodule